// File: doc/BRIEF.md
# ADC Interrupt Flag Controller

This block holds the status and interrupt flags of a twelve-channel converter that runs two conversion sequences (called sequence 0 and sequence 1 here). Event and status signals arrive from the comparators, the per-channel result registers and the two sequencers. The block turns them into one 32-bit flags word and into four request lines for interrupts or DMA. Software reads the word at any time. It clears the sticky threshold flags, and the completion flag of a sequence in completion mode, by writing ones.

All flag state is registered. A bit therefore reflects the inputs sampled at the previous rising clock edge. The four request lines combine the registered flags with the live enable bits. Each sequence has a mode bit that decides what its flag means. With mode 0 the flag shows the sequence's data-valid state: it sets when a conversion ends and clears when the sequence's global data register is read. With mode 1 the flag latches when the whole sequence finishes and holds until software writes a one to it. The two summary bits are live ORs of their source bits.

Top module: `adc_irq_flags`

## Requirements
- R1: During and after reset, with idle inputs, rd_data is all zeros and irq is all zeros.
- R2: Threshold flag bit i (bits 0 to 11) is 1 in the cycle after thr_range_hit[i] with thr_range_en[i] high, or thr_cross_hit[i] with thr_cross_en[i] high. An event whose enable is low does not set the flag.
- R3: A write with wr_en high and wr_data bit i high (i in 0 to 11) clears threshold flag i in the next cycle. A 0 in wr_data leaves the bit unchanged.
- R4: If an enabled threshold event and a write-one clear reach the same flag in the same cycle, the flag is 1 afterwards.
- R5: Bits 12 to 23 show ch_ovr (channel 0 at bit 12) one cycle late. Bits 24 and 25 show seq_ovr[0] and seq_ovr[1] one cycle late.
- R6: With seq_mode[s]=0, bit 28+s shows a data-valid latch. The latch sets the cycle after seq_conv_done[s]. It clears the cycle after seq_data_rd[s] unless seq_conv_done[s] is also high in that cycle. Writes do not change bit 28+s in this mode.
- R7: With seq_mode[s]=1, bit 28+s shows a completion latch. The latch sets the cycle after seq_end[s] and holds until a write with wr_data bit 28+s high while the mode is 1. If both arrive in the same cycle, the set wins. seq_data_rd does not clear it.
- R8: Bit 30 is 1 exactly when any of bits 0 to 11 is 1.
- R9: Bit 31 is the OR of bits 12 to 23, of bit 24 when sequence 0's registered mode is 0, and of bit 25 when sequence 1's registered mode is 0.
- R10: Bits 26 and 27 read 0. Writes have no effect on bits 12 to 27, 30 or 31.
- R11: irq[0] = bit 28 AND irq_en[0], irq[1] = bit 29 AND irq_en[1], irq[2] = bit 30 AND irq_en[2], irq[3] = bit 31 AND irq_en[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_range_hit | input | 12 | Per-channel out-of-range event pulses |
| thr_cross_hit | input | 12 | Per-channel threshold-crossing event pulses |
| thr_range_en | input | 12 | Per-channel enable for out-of-range events |
| thr_cross_en | input | 12 | Per-channel enable for crossing events |
| ch_ovr | input | 12 | Per-channel result overrun levels |
| seq_conv_done | input | 2 | End-of-conversion pulse, per sequence |
| seq_data_rd | input | 2 | Read strobe of each sequence's global data register |
| seq_end | input | 2 | Whole-sequence completion pulse |
| seq_ovr | input | 2 | Global overrun level, per sequence |
| seq_mode | input | 2 | Flag mode per sequence (0 data-valid, 1 completion) |
| irq_en | input | 4 | Request enables: seq 0, seq 1, threshold, overrun |
| wr_en | input | 1 | Write strobe for the flags word |
| wr_data | input | 32 | Write data; ones clear the writable bits |
| rd_data | output | 32 | Flags word |
| irq | output | 4 | Interrupt or DMA request lines |

## Verification
The bench targets collisions: a threshold set and its clear in the same cycle, a data read together with a new conversion, and a completion together with its clear. A design that gave priority to the clear would lose events and show 0 where 1 is expected. It also writes ones to mirror, summary and mode-0 sequence bits. A design that let those writes through would drop bits that should still follow their sources. Mode switches while both latches hold state check that bit 28+s and the overrun summary follow the mode. A design that always masked the global overrun, or picked the wrong latch, would produce a wrong bit 31 or a wrong bit 28+s.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
    localparam int CH_N    = 12;
    localparam int SEQ_N   = 2;
    localparam int WORD_W  = 32;
    localparam int REQ_N   = 4;
endpackage

// File: rtl/adc_thr_flags.sv
module adc_thr_flags #(
    parameter int N = adc_irq_pkg::CH_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] range_hit,
    input  logic [N-1:0] cross_hit,
    input  logic [N-1:0] range_en,
    input  logic [N-1:0] cross_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flag_q
);
    typedef struct packed {
        logic [N-1:0] flag;
    } thr_state_t;

    thr_state_t   st_d, st_q;
    logic [N-1:0] set_vec;

    for (genvar i = 0; i < N; i++) begin : g_ch
        assign set_vec[i] = (range_hit[i] & range_en[i]) | (cross_hit[i] & cross_en[i]);
    end

    always_comb begin
        st_d      = st_q;
        // a set in the same cycle as a clear keeps the flag
        st_d.flag = (st_q.flag & ~clr_mask) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;

    // R2 / R4: every enabled event leaves its flag set
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

    // R3: a clear without a set drops the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_vec)) |=> ((flag_q & $past(clr_mask & ~set_vec)) == '0));

    // R2: no flag rises without an enabled event
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/adc_seq_flag.sv
module adc_seq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic data_rd,
    input  logic seq_end,
    input  logic mode,
    input  logic wr_clr,
    input  logic ovr_in,
    output logic flag,
    output logic ovr_q,
    output logic mode_q
);
    typedef struct packed {
        logic valid;
        logic done;
        logic mode;
        logic ovr;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = conv_done | (st_q.valid & ~data_rd);
        st_d.done  = (mode & seq_end) | (st_q.done & ~(mode & wr_clr));
        st_d.mode  = mode;
        st_d.ovr   = ovr_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag   = st_q.mode ? st_q.done : st_q.valid;
    assign ovr_q  = st_q.ovr;
    assign mode_q = st_q.mode;

    // R6: a read with no new conversion empties the data-valid latch
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !conv_done) |=> !st_q.valid);

    // R6: a conversion always leaves the latch set
    p_conv_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> st_q.valid);

    // R7: the completion latch holds until cleared in mode 1
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !(mode && wr_clr)) |=> st_q.done);
endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags #(
    parameter int NUM_CH = adc_irq_pkg::CH_N,
    parameter int NUM_SEQ = adc_irq_pkg::SEQ_N,
    parameter int WORD_W = adc_irq_pkg::WORD_W,
    parameter int NUM_REQ = adc_irq_pkg::REQ_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] thr_range_hit,
    input  logic [NUM_CH-1:0] thr_cross_hit,
    input  logic [NUM_CH-1:0] thr_range_en,
    input  logic [NUM_CH-1:0] thr_cross_en,
    input  logic [NUM_CH-1:0] ch_ovr,
    input  logic [NUM_SEQ-1:0] seq_conv_done,
    input  logic [NUM_SEQ-1:0] seq_data_rd,
    input  logic [NUM_SEQ-1:0] seq_end,
    input  logic [NUM_SEQ-1:0] seq_ovr,
    input  logic [NUM_SEQ-1:0] seq_mode,
    input  logic [NUM_REQ-1:0] irq_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_REQ-1:0] irq
);
    localparam int OVR_LSB  = NUM_CH;
    localparam int SOVR_LSB = 2 * NUM_CH;
    localparam int SEQ_LSB  = WORD_W - 4;
    localparam int THR_SUM  = WORD_W - 2;
    localparam int OVR_SUM  = WORD_W - 1;

    typedef struct packed {
        logic [NUM_CH-1:0] ovr;
    } mirror_t;

    mirror_t            mir_d, mir_q;
    logic [NUM_CH-1:0]  thr_q;
    logic [NUM_SEQ-1:0] seq_flag, sovr_q, smode_q;
    logic               thr_sum, ovr_sum;

    always_comb begin
        mir_d     = mir_q;
        mir_d.ovr = ch_ovr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mir_q <= '0;
        else        mir_q <= mir_d;
    end

    adc_thr_flags #(.N(NUM_CH)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_hit (thr_range_hit),
        .cross_hit (thr_cross_hit),
        .range_en  (thr_range_en),
        .cross_en  (thr_cross_en),
        .clr_mask  (wr_data[NUM_CH-1:0] & {NUM_CH{wr_en}}),
        .flag_q    (thr_q)
    );

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
        adc_seq_flag u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .conv_done (seq_conv_done[s]),
            .data_rd   (seq_data_rd[s]),
            .seq_end   (seq_end[s]),
            .mode      (seq_mode[s]),
            .wr_clr    (wr_en & wr_data[SEQ_LSB+s]),
            .ovr_in    (seq_ovr[s]),
            .flag      (seq_flag[s]),
            .ovr_q     (sovr_q[s]),
            .mode_q    (smode_q[s])
        );
    end

    assign thr_sum = |thr_q;
    assign ovr_sum = (|mir_q.ovr) | (|(sovr_q & ~smode_q));

    always_comb begin
        rd_data                          = '0;
        rd_data[NUM_CH-1:0]              = thr_q;
        rd_data[OVR_LSB +: NUM_CH]       = mir_q.ovr;
        rd_data[SOVR_LSB +: NUM_SEQ]     = sovr_q;
        rd_data[SEQ_LSB +: NUM_SEQ]      = seq_flag;
        rd_data[THR_SUM]                 = thr_sum;
        rd_data[OVR_SUM]                 = ovr_sum;
    end

    assign irq = {ovr_sum, thr_sum, seq_flag} & irq_en;

    // R5: per-channel overrun bits trail their source by one cycle
    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_data[OVR_LSB +: NUM_CH] == $past(ch_ovr)));

    // R8: the threshold summary tracks the sticky flags
    p_thr_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[THR_SUM] == (rd_data[NUM_CH-1:0] != '0));

    // R11: no request line is active without its enable
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_en) == '0);
endmodule

// File: tb/adc_irq_flags_bench.sv
module adc_irq_flags_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] thr_range_hit, thr_cross_hit, thr_range_en, thr_cross_en, ch_ovr;
    logic [1:0]  seq_conv_done, seq_data_rd, seq_end, seq_ovr, seq_mode;
    logic [3:0]  irq_en;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int total = 0;
    int bad = 0;

    logic [11:0] m_thr, m_ovr;
    logic [1:0]  m_sovr, m_dv, m_done, m_mode;

    always #4 clk = ~clk;

    adc_irq_flags u_adc_irq_flags (
        .clk(clk), .rst_n(rst_n),
        .thr_range_hit(thr_range_hit), .thr_cross_hit(thr_cross_hit),
        .thr_range_en(thr_range_en), .thr_cross_en(thr_cross_en),
        .ch_ovr(ch_ovr), .seq_conv_done(seq_conv_done), .seq_data_rd(seq_data_rd),
        .seq_end(seq_end), .seq_ovr(seq_ovr), .seq_mode(seq_mode),
        .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w;
        w = '0;
        w[11:0]  = m_thr;
        w[23:12] = m_ovr;
        w[25:24] = m_sovr;
        for (int s = 0; s < 2; s++) w[28+s] = m_mode[s] ? m_done[s] : m_dv[s];
        w[30] = |m_thr;
        w[31] = (|m_ovr) | (|(m_sovr & ~m_mode));
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        thr_range_hit = '0; thr_cross_hit = '0; thr_range_en = '0; thr_cross_en = '0;
        ch_ovr = '0; seq_conv_done = '0; seq_data_rd = '0; seq_end = '0;
        seq_ovr = '0; seq_mode = '0; irq_en = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    // advance one clock: model consumes the inputs held since last negedge
    task automatic tick();
        logic [11:0] clr;
        logic [1:0]  wc;
        clr = wr_en ? wr_data[11:0] : 12'h0;
        wc  = wr_en ? wr_data[29:28] : 2'b0;
        m_thr  = (m_thr & ~clr) | (thr_range_hit & thr_range_en) | (thr_cross_hit & thr_cross_en);
        m_ovr  = ch_ovr;
        m_sovr = seq_ovr;
        m_dv   = seq_conv_done | (m_dv & ~seq_data_rd);
        m_done = (seq_mode & seq_end) | (m_done & ~(seq_mode & wc));
        m_mode = seq_mode;
        @(negedge clk);
    endtask

    task automatic check_all();
        logic [31:0] e;
        e = exp_word();
        chk("R2 threshold flags", {20'h0, rd_data[11:0]}, {20'h0, e[11:0]});
        chk("R5 overrun mirrors", {6'h0, rd_data[25:12]}, {6'h0, e[25:12]});
        for (int s = 0; s < 2; s++)
            chk(m_mode[s] ? "R7 completion flag" : "R6 data-valid flag",
                {31'h0, rd_data[28+s]}, {31'h0, e[28+s]});
        chk("R8 threshold summary", {31'h0, rd_data[30]}, {31'h0, e[30]});
        chk("R9 overrun summary", {31'h0, rd_data[31]}, {31'h0, e[31]});
        chk("R10 reserved bits", {30'h0, rd_data[27:26]}, 32'h0);
        chk("R11 request lines", {28'h0, irq},
            {28'h0, ({e[31], e[30], e[29], e[28]} & irq_en)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        m_thr = '0; m_ovr = '0; m_sovr = '0; m_dv = '0; m_done = '0; m_mode = '0;
        repeat (3) @(negedge clk);
        chk("R1 word in reset", rd_data, 32'h0);
        chk("R1 irq in reset", {28'h0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 word after reset", rd_data, 32'h0);
        irq_en = 4'hF;

        // R2 enabled range event, disabled crossing event
        thr_range_en[3] = 1'b1; thr_range_hit[3] = 1'b1; thr_cross_hit[5] = 1'b1;
        tick(); check_all();
        chk("R2 enabled event sets bit3", {31'h0, rd_data[3]}, 32'h1);
        chk("R2 disabled event leaves bit5", {31'h0, rd_data[5]}, 32'h0);
        idle(); irq_en = 4'hF;

        // R3 zero write keeps, one write clears
        wr_en = 1'b1; wr_data = 32'h0; tick();
        chk("R3 zero write keeps bit3", {31'h0, rd_data[3]}, 32'h1);
        wr_data = 32'h8; tick(); check_all();
        chk("R3 one write clears bit3", {31'h0, rd_data[3]}, 32'h0);
        idle(); irq_en = 4'hF;

        // R4 set and clear together
        thr_cross_en[7] = 1'b1; thr_cross_hit[7] = 1'b1; wr_en = 1'b1; wr_data = 32'h80;
        tick(); check_all();
        chk("R4 set beats clear", {31'h0, rd_data[7]}, 32'h1);
        idle(); irq_en = 4'hF;

        // R6 mode 0: conversion, ignored write, read
        seq_conv_done = 2'b01; tick();
        seq_conv_done = 2'b00; wr_en = 1'b1; wr_data = 32'h3000_0000; tick(); check_all();
        chk("R6 write ignored in mode 0", {31'h0, rd_data[28]}, 32'h1);
        wr_en = 1'b0; seq_data_rd = 2'b01; tick();
        chk("R6 read clears", {31'h0, rd_data[28]}, 32'h0);
        seq_data_rd = 2'b01; seq_conv_done = 2'b01; tick();
        chk("R6 new conversion beats read", {31'h0, rd_data[28]}, 32'h1);
        idle(); irq_en = 4'hF;

        // R7 mode 1: completion, read ignored, write clears
        seq_mode = 2'b10; seq_end = 2'b10; tick();
        seq_end = 2'b00; seq_data_rd = 2'b10; tick(); check_all();
        chk("R7 read does not clear", {31'h0, rd_data[29]}, 32'h1);
        seq_data_rd = 2'b00; wr_en = 1'b1; wr_data = 32'h2000_0000; tick();
        chk("R7 write clears", {31'h0, rd_data[29]}, 32'h0);
        idle(); irq_en = 4'hF;

        // R9/R10 overrun summary with mode mask, write to read-only bits
        ch_ovr = 12'h0; seq_ovr = 2'b10; seq_mode = 2'b10; wr_en = 1'b1; wr_data = 32'hFFFF_F000;
        tick(); check_all();
        chk("R9 masked global overrun", {31'h0, rd_data[31]}, 32'h0);
        seq_mode = 2'b00; tick(); check_all();
        chk("R9 unmasked global overrun", {31'h0, rd_data[31]}, 32'h1);
        idle();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            thr_range_hit = 12'($urandom) & 12'($urandom) & 12'($urandom);
            thr_cross_hit = 12'($urandom) & 12'($urandom) & 12'($urandom);
            thr_range_en  = 12'($urandom);
            thr_cross_en  = 12'($urandom);
            ch_ovr        = 12'($urandom) & 12'($urandom) & 12'($urandom);
            seq_conv_done = 2'($urandom) & 2'($urandom);
            seq_data_rd   = 2'($urandom) & 2'($urandom);
            seq_end       = 2'($urandom) & 2'($urandom);
            seq_ovr       = 2'($urandom) & 2'($urandom);
            if ($urandom_range(0, 15) == 0) seq_mode = 2'($urandom);
            irq_en        = 4'($urandom);
            wr_en         = ($urandom_range(0, 3) == 0);
            wr_data       = $urandom;
            tick();
            check_all();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule